// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor port and a byte-wide main-memory bus and keeps a direct-mapped copy of recently read memory blocks in registers. A 16-bit byte address is split into a line tag, a line index and a byte offset; every line holds one 8-byte block together with its tag and a valid bit. Read hits are answered from the line store with no bus traffic. A read miss loads the whole block with eight sequential byte reads, and the requested byte is handed to the processor as soon as its beat arrives while the rest of the block keeps loading.

Stores always go to memory. A store that hits also updates the cached byte, and a store that misses leaves the cache unchanged. Other bus masters report their writes on a snoop input that carries a block address, and a matching valid line is dropped. An address window selected by the top address bits is never cached: every access there becomes a single memory transaction.

Top module: `wtc_cache`

## Requirements
- R1: The address splits as tag = addr[15:11], line index = addr[10:3], byte offset = addr[2:0]. A miss on 0x080C fills line 1 from memory bytes 0x0808 to 0x080F, and a miss on 0x07ED fills line 253 from bytes 0x07E8 to 0x07EF.
- R2: After reset every line is invalid, so the first read of any cacheable address is a miss. cpu_ready and mem_req are low after reset.
- R3: A read that hits returns the cached byte with cpu_ready one cycle after the request is accepted and issues no memory request.
- R4: A cacheable read miss issues exactly eight memory reads of its block in ascending offset order (0 to 7). Once the fill completes, the line is valid and later reads of that block hit.
- R5: During a fill, cpu_ready pulses with the requested byte in the cycle after the beat at the requested offset is accepted, before the remaining beats are read.
- R6: A store that hits writes the byte into the line and also issues one memory write of the same address and data. Later reads of that byte hit and return the new value.
- R7: A store that misses issues one memory write and no memory reads. It neither allocates nor evicts a line.
- R8: snp_valid with a block address (addr[15:3]) whose tag and index match a valid line invalidates that line. A snoop with the same index but another tag leaves the line valid.
- R9: Addresses with addr[15:14] = 2'b11 are non-cacheable. A read there issues one memory read of the exact address, a store issues one memory write, and a repeated read goes to memory again.
- R10: cpu_ready is a single-cycle pulse. For a store or a non-cacheable read it rises only in the cycle after the memory accepts the transaction.
- R11: A snoop that hits the line addressed by a processor request in the same cycle takes priority, and the request is handled as a miss.
- R12: A snoop of the block being filled, arriving during the fill, leaves the line invalid after the fill. The next read of that block misses.
- R13: While mem_req is high and mem_ready is low, mem_req, mem_addr and mem_we hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Store data |
| cpu_rdata | output | 8 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the current transaction |
| snp_valid | input | 1 | Another master writes to memory this cycle |
| snp_line | input | 13 | Block address (addr[15:3]) of that write |

## Verification
If a valid bit or tag is wrong, the fault shows at the ports on the next access to that line. A stale hit returns data with no memory reads, and a false miss adds eight reads. Either is visible within a few cycles of the request. A wrong fill beat counter shows up as out-of-order fill addresses, or as cpu_ready arriving after the wrong beat count. The sweep touches every line index, so a fault confined to one line's storage shows up as a wrong read count or wrong data on that line.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_WRITE  = 2'd2,
    ST_NCREAD = 2'd3
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int TAG_W = 5,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             sn_valid,
  input  logic [IDX_W-1:0] sn_idx,
  input  logic [TAG_W-1:0] sn_tag,
  output logic             sn_hit,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             fin_en,
  input  logic [IDX_W-1:0] fin_idx
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign sn_hit = sn_valid && valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);

  // Snoop invalidation is applied last so it wins over every other update.
  always_comb begin
    valid_d = valid_q;
    if (alloc_en) valid_d[alloc_idx] = 1'b0;
    if (fin_en)   valid_d[fin_idx]   = 1'b1;
    if (sn_hit)   valid_d[sn_idx]    = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[alloc_idx] <= alloc_tag;
  end

  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sn_hit |=> !valid_q[$past(sn_idx)]); // R8

  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_en && !(sn_hit && sn_idx == fin_idx)) |=> valid_q[$past(fin_idx)]); // R4
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int BYTES = 1 << OFF_W;

  logic [DATA_W-1:0] line_rd [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [DATA_W-1:0] bytes_q [BYTES];
    logic              line_we;

    assign line_we = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (line_we) bytes_q[wr_off] <= wr_data;
    end

    assign line_rd[i] = bytes_q[rd_off];
  end

  assign rd_data = line_rd[rd_idx];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int TAG_W   = 5,
  parameter int IDX_W   = 8,
  parameter int OFF_W   = 3,
  parameter int DATA_W  = 8,
  parameter int NC_BITS = 2,
  parameter logic [NC_BITS-1:0] NC_MATCH = '1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cpu_req,
  input  logic                            cpu_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]               cpu_wdata,
  output logic [DATA_W-1:0]               cpu_rdata,
  output logic                            cpu_ready,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]               mem_wdata,
  input  logic [DATA_W-1:0]               mem_rdata,
  input  logic                            mem_ready,
  input  logic                            snp_valid,
  input  logic [TAG_W+IDX_W-1:0]          snp_line,
  input  logic                            lk_hit,
  input  logic                            snp_kill,
  input  logic [DATA_W-1:0]               rd_data,
  output logic                            alloc_en,
  output logic [IDX_W-1:0]                alloc_idx,
  output logic [TAG_W-1:0]                alloc_tag,
  output logic                            fin_en,
  output logic [IDX_W-1:0]                fin_idx,
  output logic                            dwr_en,
  output logic [IDX_W-1:0]                dwr_idx,
  output logic [OFF_W-1:0]                dwr_off,
  output logic [DATA_W-1:0]               dwr_data
);
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
  localparam int BLK_W  = TAG_W + IDX_W;

  wtc_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic [OFF_W-1:0]    beat_q, beat_d;
  logic                poison_q, poison_d;
  logic                ready_q, ready_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;

  logic                cpu_nc;
  logic                accept;
  logic                hit;
  logic                snp_on_fill;
  logic                last_beat;

  assign cpu_nc      = (cpu_addr[ADDR_W-1 -: NC_BITS] == NC_MATCH);
  assign accept      = (state_q == ST_IDLE) && cpu_req && !ready_q;
  assign hit         = !cpu_nc && lk_hit && !snp_kill;
  assign snp_on_fill = snp_valid && (snp_line == addr_q[ADDR_W-1:OFF_W]);
  assign last_beat   = (beat_q == {OFF_W{1'b1}});

  assign alloc_idx = cpu_addr[OFF_W +: IDX_W];
  assign alloc_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign fin_idx   = addr_q[OFF_W +: IDX_W];

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    beat_d    = beat_q;
    poison_d  = poison_q;
    ready_d   = 1'b0;
    rdata_d   = rdata_q;
    alloc_en  = 1'b0;
    fin_en    = 1'b0;
    dwr_en    = 1'b0;
    dwr_idx   = cpu_addr[OFF_W +: IDX_W];
    dwr_off   = cpu_addr[OFF_W-1:0];
    dwr_data  = cpu_wdata;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          addr_d  = cpu_addr;
          wdata_d = cpu_wdata;
          if (cpu_we) begin
            dwr_en  = hit;
            state_d = ST_WRITE;
          end else if (cpu_nc) begin
            state_d = ST_NCREAD;
          end else if (hit) begin
            rdata_d = rd_data;
            ready_d = 1'b1;
          end else begin
            alloc_en = 1'b1;
            beat_d   = '0;
            poison_d = 1'b0;
            state_d  = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {addr_q[ADDR_W-1:OFF_W], beat_q};
        if (snp_on_fill) poison_d = 1'b1;
        if (mem_ready) begin
          dwr_en   = 1'b1;
          dwr_idx  = addr_q[OFF_W +: IDX_W];
          dwr_off  = beat_q;
          dwr_data = mem_rdata;
          if (beat_q == addr_q[OFF_W-1:0]) begin
            rdata_d = mem_rdata;
            ready_d = 1'b1;
          end
          if (last_beat) begin
            fin_en  = !(poison_q || snp_on_fill);
            state_d = ST_IDLE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      ST_WRITE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ready) begin
          ready_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_NCREAD: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          rdata_d = mem_rdata;
          ready_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk) begin
    addr_q   <= addr_d;
    wdata_q  <= wdata_d;
    beat_q   <= beat_d;
    poison_q <= poison_d;
    rdata_q  <= rdata_d;
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13

  AST_FILL_CACHEABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |-> (addr_q[ADDR_W-1 -: NC_BITS] != NC_MATCH)); // R9

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_we && hit) |=> (!mem_req && cpu_ready)); // R3
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
  parameter int TAG_W   = 5,
  parameter int IDX_W   = 8,
  parameter int OFF_W   = 3,
  parameter int DATA_W  = 8,
  parameter int NC_BITS = 2,
  parameter logic [NC_BITS-1:0] NC_MATCH = '1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         cpu_ready,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata,
  input  logic                         mem_ready,
  input  logic                         snp_valid,
  input  logic [TAG_W+IDX_W-1:0]       snp_line
);
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;

  logic              lk_hit;
  logic              sn_hit;
  logic              snp_kill;
  logic [DATA_W-1:0] rd_data;
  logic              alloc_en;
  logic [IDX_W-1:0]  alloc_idx;
  logic [TAG_W-1:0]  alloc_tag;
  logic              fin_en;
  logic [IDX_W-1:0]  fin_idx;
  logic              dwr_en;
  logic [IDX_W-1:0]  dwr_idx;
  logic [OFF_W-1:0]  dwr_off;
  logic [DATA_W-1:0] dwr_data;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign snp_kill = sn_hit && (snp_line[IDX_W-1:0] == cpu_addr[OFF_W +: IDX_W]);

  wtc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) tags_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .lk_idx    (cpu_addr[OFF_W +: IDX_W]),
    .lk_tag    (cpu_addr[ADDR_W-1 -: TAG_W]),
    .lk_hit    (lk_hit),
    .sn_valid  (snp_valid),
    .sn_idx    (snp_line[IDX_W-1:0]),
    .sn_tag    (snp_line[IDX_W +: TAG_W]),
    .sn_hit    (sn_hit),
    .alloc_en  (alloc_en),
    .alloc_idx (alloc_idx),
    .alloc_tag (alloc_tag),
    .fin_en    (fin_en),
    .fin_idx   (fin_idx)
  );

  wtc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) data_i (
    .clk     (clk),
    .rd_idx  (cpu_addr[OFF_W +: IDX_W]),
    .rd_off  (cpu_addr[OFF_W-1:0]),
    .rd_data (rd_data),
    .wr_en   (dwr_en),
    .wr_idx  (dwr_idx),
    .wr_off  (dwr_off),
    .wr_data (dwr_data)
  );

  wtc_ctrl #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
    .NC_BITS(NC_BITS), .NC_MATCH(NC_MATCH)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .snp_valid (snp_valid),
    .snp_line  (snp_line),
    .lk_hit    (lk_hit),
    .snp_kill  (snp_kill),
    .rd_data   (rd_data),
    .alloc_en  (alloc_en),
    .alloc_idx (alloc_idx),
    .alloc_tag (alloc_tag),
    .fin_en    (fin_en),
    .fin_idx   (fin_idx),
    .dwr_en    (dwr_en),
    .dwr_idx   (dwr_idx),
    .dwr_off   (dwr_off),
    .dwr_data  (dwr_data)
  );
endmodule

// File: tb/wtc_cache_tb_top.sv
module wtc_cache_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic        cpu_req;
  logic        cpu_we;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_ready;
  logic        snp_valid;
  logic [12:0] snp_line;

  wtc_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .snp_valid(snp_valid), .snp_line(snp_line)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int lat     = 1;
  int wait_cnt = 0;
  int cyc_total = 0;

  logic [7:0]  wmem [logic [15:0]];
  logic [15:0] rd_log [16];
  int          nrd, nwr;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  bit          resp_seen;
  logic [7:0]  resp_data;
  int          resp_beats;
  int          resp_cyc;

  function automatic logic [7:0] mval(input logic [15:0] a);
    if (wmem.exists(a)) return wmem[a];
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] mk(input int tag, input int idx, input int off);
    return {tag[4:0], idx[7:0], off[2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory responder and response monitor, evaluated away from the active edge.
  always @(negedge clk) begin
    if (cpu_ready) begin
      resp_seen  = 1'b1;
      resp_data  = cpu_rdata;
      resp_beats = nrd;
    end
    if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ready = 1'b1;
        wait_cnt  = 0;
        if (mem_we) begin
          nwr++;
          wr_addr = mem_addr;
          wr_data = mem_wdata;
          wmem[mem_addr] = mem_wdata;
        end else begin
          if (nrd < 16) rd_log[nrd] = mem_addr;
          nrd++;
          mem_rdata = mval(mem_addr);
        end
      end else begin
        mem_ready = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total >= 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc_total);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic drive_snoop(input logic [15:0] a);
    snp_valid = 1'b1;
    snp_line  = a[15:3];
  endtask

  // One processor access; snp_at >= 0 drives a snoop of snp_a at that cycle.
  task automatic access(input logic [15:0] a, input bit we, input logic [7:0] wd,
                        input int snp_at, input logic [15:0] snp_a);
    int  cyc;
    bit  got;
    nrd = 0; nwr = 0; resp_seen = 1'b0; got = 1'b0; resp_cyc = -1;
    @(negedge clk); #1;
    cpu_addr = a; cpu_we = we; cpu_wdata = wd; cpu_req = 1'b1;
    cyc = 0;
    if (snp_at == 0) drive_snoop(snp_a);
    forever begin
      @(negedge clk); #1;
      snp_valid = 1'b0;
      cyc++;
      if (resp_seen && !got) begin
        got = 1'b1;
        resp_cyc = cyc;
        cpu_req = 1'b0;
      end
      if (cyc == snp_at) drive_snoop(snp_a);
      if (got && !mem_req && !snp_valid) break;
      if (cyc > 300) begin
        chk(1'b0, "R10", "access timeout", cyc, 300);
        cpu_req = 1'b0;
        break;
      end
    end
  endtask

  task automatic rd(input logic [15:0] a);
    access(a, 1'b0, 8'h00, -1, 16'h0);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    access(a, 1'b1, d, -1, 16'h0);
  endtask

  task automatic snoop_only(input logic [15:0] a);
    @(negedge clk); #1;
    drive_snoop(a);
    @(negedge clk); #1;
    snp_valid = 1'b0;
  endtask

  task automatic chk_miss(input logic [15:0] a, input string req);
    for (int i = 0; i < 8; i++)
      chk(rd_log[i] == {a[15:3], 3'(i)}, req, "fill address", rd_log[i], {a[15:3], 3'(i)});
    chk(nrd == 8, req, "fill read count", nrd, 8);
    chk(resp_data == mval(a), req, "miss data", resp_data, mval(a));
    chk(resp_beats == int'(a[2:0]) + 1, "R5", "beats before ready", resp_beats, int'(a[2:0]) + 1);
    chk(resp_cyc == (int'(a[2:0]) + 1) * (lat + 1) + 1, "R5", "forward cycle",
        resp_cyc, (int'(a[2:0]) + 1) * (lat + 1) + 1);
  endtask

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    snp_valid = 1'b0; snp_line = '0; mem_ready = 1'b0; mem_rdata = '0;
    nrd = 0; nwr = 0; resp_seen = 1'b0; resp_data = '0; resp_beats = 0; resp_cyc = 0;
    wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(cpu_ready == 1'b0, "R2", "cpu_ready after reset", cpu_ready, 0);
    chk(mem_req == 1'b0, "R2", "mem_req after reset", mem_req, 0);

    // R2/R4: every line starts invalid; sweep all indices, then re-read for hits
    for (int idx = 0; idx < 256; idx++) begin
      logic [15:0] a;
      a = mk((idx % 22) + 2, idx, idx % 8);
      lat = idx % 3;
      rd(a);
      chk(nrd == 8, "R2", "first read misses", nrd, 8);
      chk(resp_data == mval(a), "R4", "sweep miss data", resp_data, mval(a));
    end
    for (int idx = 0; idx < 256; idx++) begin
      logic [15:0] a;
      a = mk((idx % 22) + 2, idx, (idx + 3) % 8);
      rd(a);
      chk(nrd == 0, "R4", "refill line hits", nrd, 0);
      chk(resp_data == mval(a), "R4", "sweep hit data", resp_data, mval(a));
    end

    // R1/R5: decode examples, forwarding point for several latencies
    lat = 1; rd(16'h080C); chk_miss(16'h080C, "R1");
    lat = 2; rd(16'h07ED); chk_miss(16'h07ED, "R1");
    lat = 0; rd(mk(9, 40, 7)); chk_miss(mk(9, 40, 7), "R5");
    lat = 3; rd(mk(9, 41, 0)); chk_miss(mk(9, 41, 0), "R5");

    // R3: hits on every byte of line 1, one cycle latency, no bus
    lat = 1;
    for (int o = 0; o < 8; o++) begin
      logic [15:0] a;
      a = 16'h0808 + 16'(o);
      rd(a);
      chk(nrd == 0 && nwr == 0, "R3", "hit bus traffic", nrd + nwr, 0);
      chk(resp_cyc == 1, "R3", "hit latency", resp_cyc, 1);
      chk(resp_data == mval(a), "R3", "hit data", resp_data, mval(a));
    end

    // R6/R10: write hit goes to cache and memory
    lat = 2;
    wr(16'h080C, 8'hC3);
    chk(nwr == 1 && nrd == 0, "R6", "write hit bus ops", nwr * 16 + nrd, 16);
    chk(wr_addr == 16'h080C && wr_data == 8'hC3, "R6", "write-through addr/data",
        {wr_addr, wr_data}, {16'h080C, 8'hC3});
    chk(resp_cyc == lat + 2, "R10", "write ready cycle", resp_cyc, lat + 2);
    rd(16'h080C);
    chk(nrd == 0 && resp_data == 8'hC3, "R6", "updated byte hits", {nrd[7:0], resp_data}, 16'h00C3);

    // R7: write miss, no allocate, no eviction
    lat = 1;
    wr(16'h1234, 8'h3C);
    chk(nwr == 1 && nrd == 0, "R7", "write miss bus ops", nwr * 16 + nrd, 16);
    rd(mk(6, 70, 1));
    chk(nrd == 0, "R7", "resident line kept", nrd, 0);
    rd(16'h1234);
    chk(nrd == 8, "R7", "no allocation on write miss", nrd, 8);
    chk(resp_data == 8'h3C, "R7", "memory holds store", resp_data, 8'h3C);

    // R8: snoop with other tag ignored, matching snoop invalidates
    snoop_only(mk(15, 12, 0));
    rd(mk(14, 12, 2));
    chk(nrd == 0, "R8", "mismatched snoop keeps line", nrd, 0);
    snoop_only(mk(14, 12, 6));
    rd(mk(14, 12, 2));
    chk(nrd == 8, "R8", "matching snoop invalidates", nrd, 8);

    // R9: non-cacheable window
    lat = 2;
    rd(16'hC123);
    chk(nrd == 1 && rd_log[0] == 16'hC123, "R9", "nc single read", nrd, 1);
    chk(resp_data == mval(16'hC123), "R9", "nc data", resp_data, mval(16'hC123));
    chk(resp_cyc == lat + 2, "R10", "nc ready cycle", resp_cyc, lat + 2);
    rd(16'hC123);
    chk(nrd == 1, "R9", "nc repeated read goes to bus", nrd, 1);
    wr(16'hFFFF, 8'h77);
    chk(nwr == 1 && wr_addr == 16'hFFFF, "R9", "nc write", nwr, 1);
    rd(16'hFFFF);
    chk(nrd == 1 && resp_data == 8'h77, "R9", "nc read after write", {nrd[7:0], resp_data}, 16'h0177);

    // R11: simultaneous snoop on the requested line forces a miss
    lat = 1;
    access(mk(7, 5, 5), 1'b0, 8'h00, 0, mk(7, 5, 0));
    chk(nrd == 8, "R11", "snoop-same-cycle miss", nrd, 8);
    access(mk(7, 5, 5), 1'b0, 8'h00, 0, mk(7, 6, 0));
    chk(nrd == 0, "R11", "snoop other line keeps hit", nrd, 0);

    // R12: snoop of the block under fill leaves it invalid
    access(mk(20, 9, 2), 1'b0, 8'h00, 4, mk(20, 9, 7));
    chk(nrd == 8 && resp_data == mval(mk(20, 9, 2)), "R12", "fill data", resp_data, mval(mk(20, 9, 2)));
    rd(mk(20, 9, 2));
    chk(nrd == 8, "R12", "poisoned fill not kept", nrd, 8);
    rd(mk(20, 9, 3));
    chk(nrd == 0, "R12", "clean refill kept", nrd, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule